// File: doc/BRIEF.md
# Two-Level Shared Bus Arbiter

This block decides which master owns a single internal memory bus. The contenders are a CPU/cache master, a DMA engine shared by two clients, an optional external master and a memory refresh requester. The two DMA clients are a fast Ethernet channel and a communications processor. The communications processor in turn carries either bulk-DMA requests or serial-channel requests. Each source has a request line, a burst/single qualifier and a transaction-done line. The arbiter answers with a one-hot grant vector, an owner code and a burst flag for the current tenure.

A tenure starts on the clock edge at which a winner is picked. It lasts until the owner pulses its done line. The DMA engine outranks the CPU, but it gives the bus back after every transaction, so a waiting CPU always gets the next tenure. Inside the engine, the Ethernet and communications clients take turns. The external master is cut off after a fixed number of cycles, and it may not take two tenures in a row while an internal master waits. When nothing requests, the bus rests on the CPU.

Top module: `ab_bus_arb`

## Requirements
- R1: During and after reset, and whenever no source requests at a decision point, the bus is parked on the CPU: grant is 6'b000001, owner is 0 and the burst flag is 0. Exactly one grant bit is high at every cycle.
- R2: A tenure is held until its owner pulses done. The next owner appears on the outputs in the cycle after the done pulse, so a tenure ended by done in its k-th cycle lasts k cycles.
- R3: Refresh (index 5) wins every decision point it requests at, ahead of all other sources.
- R4: With ext_en high, the external master (index 4) outranks the CPU and both DMA clients. With ext_en low, its request is ignored.
- R5: An external tenure is ended by the arbiter after EXT_MAX_CYC cycles if done has not come. After an external tenure, a waiting internal source wins the next decision point over the external master.
- R6: A DMA client beats the CPU, unless the previous CPU-or-DMA tenure went to a DMA client and the CPU requests. With CPU, Ethernet and bulk all requesting from reset, owners run 1, 0, 2, 0, 1.
- R7: The Ethernet client (index 1) and the communications client (index 2 or 3) alternate when both request. Ethernet wins the first tie after reset.
- R8: Within the communications client, bulk (index 2) beats serial (index 3) when bulk_low is 0. Serial beats bulk when bulk_low is 1.
- R9: The burst flag copies the winner's burst qualifier, except that a serial tenure always reports 0.
- R10: The owner code is the index of the granted source: 0 CPU, 1 Ethernet, 2 bulk, 3 serial, 4 external, 5 refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_en | input | 1 | Enables the external master |
| bulk_low | input | 1 | 1: serial beats bulk inside the communications client |
| req | input | 6 | Request per source, indexed by owner code |
| burst | input | 6 | Burst (1) or single (0) qualifier per source |
| done | input | 6 | Transaction-done pulse per source |
| grant | output | 6 | One-hot grant |
| owner | output | 3 | Code of the granted source |
| own_burst | output | 1 | Current tenure is a burst |

## Verification
Steady CPU, Ethernet and bulk requests are used to separate the DMA-over-CPU yield rule from the round-robin between the two DMA clients. They also measure tenure length against the done pulse. Paired bulk and serial requests, run under both settings of bulk_low, check the inner priority and the serial burst override. Refresh arriving mid-tenure tests preemption at the boundary. An external master that never signals done tests the forced cut-off and the no-back-to-back rule, and the same master with ext_en low must never receive the bus. Pseudo-random request and qualifier streams then compare the outputs cycle by cycle against a behavioural model.

// File: rtl/ab_pkg.sv
package ab_pkg;
    localparam int NSRC  = 6;
    localparam int NINT  = 4;
    localparam int SRC_W = $clog2(NSRC);

    typedef enum logic [SRC_W-1:0] {
        SRC_CPU  = 3'd0,
        SRC_ETH  = 3'd1,
        SRC_BULK = 3'd2,
        SRC_SER  = 3'd3,
        SRC_EXT  = 3'd4,
        SRC_RFSH = 3'd5
    } src_e;

    typedef struct packed {
        src_e owner;
        logic busy;
        logic burst;
    } tenure_t;

    typedef struct packed {
        logic dma_last;
        logic comm_next;
        logic ext_last;
    } hist_t;

    function automatic logic is_dma(input src_e s);
        return (s == SRC_ETH) || (s == SRC_BULK) || (s == SRC_SER);
    endfunction

    function automatic src_e comm_pick(input logic bulk_req, input logic ser_req,
                                       input logic bulk_low);
        if (bulk_low) return ser_req ? SRC_SER : SRC_BULK;
        return bulk_req ? SRC_BULK : SRC_SER;
    endfunction
endpackage

// File: rtl/ab_dma_pick.sv
module ab_dma_pick
    import ab_pkg::*;
(
    input  logic eth_req,
    input  logic bulk_req,
    input  logic ser_req,
    input  logic comm_next,
    input  logic bulk_low,
    output logic any_req,
    output src_e pick
);
    logic comm_req;

    always_comb begin
        comm_req = bulk_req | ser_req;
        any_req  = eth_req | comm_req;
        if (eth_req && (!comm_req || !comm_next)) pick = SRC_ETH;
        else                                      pick = comm_pick(bulk_req, ser_req, bulk_low);
    end
endmodule

// File: rtl/ab_ext_limit.sv
module ab_ext_limit #(
    parameter int MAX_CYC = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic active,
    output logic expire
);
    localparam int CW = $clog2(MAX_CYC + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || restart) cnt_q <= '0;
        else if (active)    cnt_q <= cnt_q + 1'b1;
    end

    assign expire = active && (cnt_q == CW'(MAX_CYC - 1));
endmodule

// File: rtl/ab_bus_arb.sv
module ab_bus_arb
    import ab_pkg::*;
#(
    parameter int EXT_MAX_CYC = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ext_en,
    input  logic             bulk_low,
    input  logic [NSRC-1:0]  req,
    input  logic [NSRC-1:0]  burst,
    input  logic [NSRC-1:0]  done,
    output logic [NSRC-1:0]  grant,
    output logic [SRC_W-1:0] owner,
    output logic             own_burst
);
    tenure_t         ten_q, ten_d;
    hist_t           hist_q, hist_d;
    logic [NSRC-1:0] req_eff;
    logic            dma_any, ext_active, ext_expire, boundary, have_win;
    src_e            dma_src, win;

    always_comb begin
        req_eff = req;
        if (!ext_en) req_eff[SRC_EXT] = 1'b0;
    end

    ab_dma_pick u_dma (
        .eth_req  (req_eff[SRC_ETH]),
        .bulk_req (req_eff[SRC_BULK]),
        .ser_req  (req_eff[SRC_SER]),
        .comm_next(hist_q.comm_next),
        .bulk_low (bulk_low),
        .any_req  (dma_any),
        .pick     (dma_src)
    );

    assign ext_active = ten_q.busy && (ten_q.owner == SRC_EXT);
    assign boundary   = !ten_q.busy || done[ten_q.owner] || ext_expire;

    ab_ext_limit #(.MAX_CYC(EXT_MAX_CYC)) u_lim (
        .clk    (clk),
        .rst    (rst),
        .restart(boundary),
        .active (ext_active),
        .expire (ext_expire)
    );

    // Decision order: refresh, external (unless it just had the bus), CPU/DMA yield rule.
    always_comb begin
        have_win = 1'b1;
        win      = SRC_CPU;
        if (req_eff[SRC_RFSH])
            win = SRC_RFSH;
        else if (req_eff[SRC_EXT] && !(hist_q.ext_last && |req_eff[NINT-1:0]))
            win = SRC_EXT;
        else if (req_eff[SRC_CPU] && (!dma_any || hist_q.dma_last))
            win = SRC_CPU;
        else if (dma_any)
            win = dma_src;
        else
            have_win = 1'b0;
    end

    always_comb begin
        ten_d  = ten_q;
        hist_d = hist_q;
        if (boundary) begin
            if (have_win) begin
                ten_d.owner     = win;
                ten_d.busy      = 1'b1;
                ten_d.burst     = (win == SRC_SER) ? 1'b0 : burst[win];
                hist_d.ext_last = (win == SRC_EXT);
                if (win == SRC_CPU)  hist_d.dma_last = 1'b0;
                else if (is_dma(win)) hist_d.dma_last = 1'b1;
                if (win == SRC_ETH) hist_d.comm_next = 1'b1;
                else if ((win == SRC_BULK) || (win == SRC_SER)) hist_d.comm_next = 1'b0;
            end else begin
                ten_d = '{owner: SRC_CPU, busy: 1'b0, burst: 1'b0};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ten_q  <= '{owner: SRC_CPU, busy: 1'b0, burst: 1'b0};
            hist_q <= '0;
        end else begin
            ten_q  <= ten_d;
            hist_q <= hist_d;
        end
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_gnt
        assign grant[g] = (ten_q.owner == src_e'(g));
    end

    assign owner     = ten_q.owner;
    assign own_burst = ten_q.burst;
endmodule

// File: rtl/ab_bus_arb_chk.sv
module ab_bus_arb_chk
    import ab_pkg::*;
#(
    parameter int EXT_MAX_CYC = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             ext_en,
    input logic [NSRC-1:0]  req,
    input logic [NSRC-1:0]  done,
    input logic [NSRC-1:0]  grant,
    input logic [SRC_W-1:0] owner,
    input logic             own_burst,
    input logic             busy,
    input logic             boundary
);
    int ext_run;

    always_ff @(posedge clk) begin
        if (rst || boundary)                   ext_run <= 0;
        else if (busy && owner == SRC_EXT)     ext_run <= ext_run + 1;
    end

    assert_grant_onehot_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot(grant) && grant[owner]);

    assert_park_R1: assert property (@(posedge clk) disable iff (rst)
        (boundary && req == '0) |=> (owner == SRC_CPU));

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (busy && !done[owner] && owner != SRC_EXT) |=> $stable(owner));

    assert_refresh_R3: assert property (@(posedge clk) disable iff (rst)
        (boundary && req[SRC_RFSH]) |=> (owner == SRC_RFSH));

    assert_ext_off_R4: assert property (@(posedge clk) disable iff (rst)
        (boundary && !ext_en) |=> (owner != SRC_EXT));

    assert_ext_limit_R5: assert property (@(posedge clk) disable iff (rst)
        (busy && owner == SRC_EXT) |-> (ext_run < EXT_MAX_CYC));

    assert_serial_single_R9: assert property (@(posedge clk) disable iff (rst)
        (owner == SRC_SER) |-> !own_burst);
endmodule

bind ab_bus_arb ab_bus_arb_chk #(.EXT_MAX_CYC(EXT_MAX_CYC)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ext_en   (ext_en),
    .req      (req),
    .done     (done),
    .grant    (grant),
    .owner    (owner),
    .own_burst(own_burst),
    .busy     (ten_q.busy),
    .boundary (boundary)
);

// File: tb/test_ab_bus_arb.sv
module test_ab_bus_arb;
    localparam int EXT_MAX = 8;

    logic       clk = 1'b0, rst = 1'b1, ext_en = 1'b0, bulk_low = 1'b0;
    logic [5:0] req = '0, burst = '0, done = '0;
    logic [5:0] grant;
    logic [2:0] owner;
    logic       own_burst;

    always #4 clk = ~clk;

    ab_bus_arb #(.EXT_MAX_CYC(EXT_MAX)) i_ab_bus_arb (
        .clk(clk), .rst(rst), .ext_en(ext_en), .bulk_low(bulk_low),
        .req(req), .burst(burst), .done(done),
        .grant(grant), .owner(owner), .own_burst(own_burst)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;

    // behavioural reference state
    int m_owner = 0, m_age = 0;
    bit m_busy = 0, m_burst = 0, m_dma_last = 0, m_comm_next = 0, m_ext_last = 0;

    // stimulus state
    bit [5:0] want = '0, burst_cfg = '0;
    bit       ext_hang = 0, rnd_mode = 0;
    logic [15:0] lfsr = 16'hACE1;
    int log_own[$];
    int log_cyc[$];
    int prev_owner = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        bit [5:0] r;
        bit bnd, dma, comm, cpu;
        int w;
        cyc++;
        if (rst) begin
            m_owner = 0; m_busy = 0; m_burst = 0; m_age = 0;
            m_dma_last = 0; m_comm_next = 0; m_ext_last = 0;
        end else begin
            r = req;
            if (!ext_en) r[4] = 0;
            bnd = !m_busy || done[m_owner] || (m_owner == 4 && m_age == EXT_MAX - 1);
            if (bnd) begin
                w = -1;
                dma = r[1] | r[2] | r[3];
                comm = r[2] | r[3];
                cpu = r[0];
                if (r[5]) w = 5;
                else if (r[4] && !(m_ext_last && r[3:0] != 0)) w = 4;
                else if (cpu && (!dma || m_dma_last)) w = 0;
                else if (dma) begin
                    if (r[1] && (!comm || !m_comm_next)) w = 1;
                    else if (bulk_low) w = r[3] ? 3 : 2;
                    else w = r[2] ? 2 : 3;
                end
                if (w >= 0) begin
                    m_owner = w; m_busy = 1;
                    m_burst = (w == 3) ? 1'b0 : burst[w];
                    m_ext_last = (w == 4);
                    if (w == 0) m_dma_last = 0;
                    else if (w >= 1 && w <= 3) m_dma_last = 1;
                    if (w == 1) m_comm_next = 1;
                    else if (w == 2 || w == 3) m_comm_next = 0;
                end else begin
                    m_owner = 0; m_busy = 0; m_burst = 0;
                end
                m_age = 0;
            end else begin
                m_age++;
            end
        end
    end

    always @(negedge clk) begin
        int len;
        if (!rst) begin
            check(grant == 6'(1 << m_owner), "R1 grant vs model", int'(grant), 1 << m_owner);
            check(int'(owner) == m_owner, "R10 owner vs model", int'(owner), m_owner);
            check(own_burst == m_burst, "R9 burst vs model", int'(own_burst), int'(m_burst));
            if (int'(owner) != prev_owner) begin
                log_own.push_back(int'(owner));
                log_cyc.push_back(cyc);
            end
            prev_owner = int'(owner);
        end else begin
            prev_owner = 0;
        end
        if (rnd_mode) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            req = lfsr[5:0] & {lfsr[9] & lfsr[11], 5'h1F};
            burst = lfsr[13:8];
        end else begin
            req = want;
            burst = burst_cfg;
        end
        done = '0;
        if (!rst && m_busy && !(m_owner == 4 && ext_hang)) begin
            len = m_burst ? 4 : 1;
            if (m_age == len - 1) done[m_owner] = 1'b1;
        end
    end

    task automatic run(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic restart();
        rst = 1'b1;
        run(2);
        rst = 1'b0;
        log_own.delete();
        log_cyc.delete();
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R2 watchdog expired actual=%0d expected=0", cyc);
        finish_run();
    end

    initial begin
        run(1);
        // R1: reset state, then parked with no requests
        rst = 1'b1;
        run(3);
        check(grant == 6'b000001, "R1 reset grant", int'(grant), 1);
        check(owner == 3'd0, "R1 reset owner", int'(owner), 0);
        check(own_burst == 1'b0, "R1 reset burst", int'(own_burst), 0);
        rst = 1'b0;
        run(5);
        check(owner == 3'd0 && grant == 6'b000001, "R1 idle park", int'(grant), 1);

        // R6, R7, R2: CPU + Ethernet + bulk all requesting
        restart();
        want = 6'b000111; burst_cfg = 6'b000111;
        run(40);
        check(log_own.size() >= 5, "R6 tenure count", log_own.size(), 5);
        if (log_own.size() >= 5) begin
            check(log_own[0] == 1, "R7 first tie to Ethernet", log_own[0], 1);
            check(log_own[1] == 0, "R6 CPU after DMA", log_own[1], 0);
            check(log_own[2] == 2, "R7 comms after Ethernet", log_own[2], 2);
            check(log_own[3] == 0, "R6 CPU after comms", log_own[3], 0);
            check(log_own[4] == 1, "R7 back to Ethernet", log_own[4], 1);
            check(log_cyc[1] - log_cyc[0] == 4, "R2 burst tenure length", log_cyc[1] - log_cyc[0], 4);
        end

        // R8, R9: bulk vs serial
        restart();
        bulk_low = 1'b1; want = 6'b001100; burst_cfg = 6'b001100;
        run(3);
        check(owner == 3'd3, "R8 serial first when bulk low", int'(owner), 3);
        check(own_burst == 1'b0, "R9 serial forced single", int'(own_burst), 0);
        restart();
        bulk_low = 1'b0;
        run(3);
        check(owner == 3'd2, "R8 bulk first", int'(owner), 2);
        check(own_burst == 1'b1, "R9 bulk burst copied", int'(own_burst), 1);

        // R3: refresh arriving mid-tenure
        restart();
        want = 6'b000011; burst_cfg = 6'b000011;
        run(2);
        want[5] = 1'b1;
        run(10);
        check(log_own.size() >= 2, "R3 tenure count", log_own.size(), 2);
        if (log_own.size() >= 2) begin
            check(log_own[0] == 1, "R3 Ethernet before refresh", log_own[0], 1);
            check(log_own[1] == 5, "R3 refresh next", log_own[1], 5);
        end
        want = '0;

        // R5: external master never signals done
        restart();
        ext_en = 1'b1; ext_hang = 1'b1; want = 6'b010001; burst_cfg = 6'b010001;
        run(40);
        check(log_own.size() >= 3, "R5 tenure count", log_own.size(), 3);
        if (log_own.size() >= 3) begin
            check(log_own[0] == 4, "R4 external first", log_own[0], 4);
            check(log_own[1] == 0, "R5 CPU after external", log_own[1], 0);
            check(log_own[2] == 4, "R5 external again", log_own[2], 4);
            check(log_cyc[1] - log_cyc[0] == EXT_MAX, "R5 forced cut-off", log_cyc[1] - log_cyc[0], EXT_MAX);
        end

        // R4: external outranks Ethernet; ignored when disabled
        restart();
        ext_hang = 1'b0; want = 6'b010010; burst_cfg = 6'b010010;
        run(3);
        check(owner == 3'd4, "R4 external over Ethernet", int'(owner), 4);
        restart();
        ext_en = 1'b0; want = 6'b010000;
        run(6);
        check(grant == 6'b000001, "R4 disabled external ignored", int'(grant), 1);
        check(log_own.size() == 0, "R4 no ownership change", log_own.size(), 0);

        // Pseudo-random streams against the model
        for (int k = 0; k < 4; k++) begin
            restart();
            ext_en = k[0]; bulk_low = k[1]; ext_hang = (k == 3);
            rnd_mode = 1'b1;
            run(400);
            rnd_mode = 1'b0;
        end
        want = '0;
        run(2);
        finish_run();
    end
endmodule